// File: doc/BRIEF.md
# Strobed Parallel Output Engine

The engine streams a run of data items out of an on-chip RAM window onto an external parallel bus, with a strobe that marks each item. It reads 32-bit words through a simple request/valid read port. It splits each word little-endian into 8-bit or 16-bit items. Each item is placed on the pins for a programmed number of setup cycles. The strobe is then driven to its active level for a programmed width. The data is held for a programmed number of hold cycles before the next item replaces it.

Software programs the width, strobe polarity, the three phase lengths, an item count and a word-aligned start address, then raises a start bit. One interrupt pulse marks the end of the run. Clearing the start bit abandons a run at any point.

Top module: `par_out_engine`

## Requirements
- R1: After reset the strobe is at its inactive level, no read is requested, the interrupt is low and the data pins are zero.
- R2: In 8-bit mode each word yields four items, byte 0 (bits 7:0) first and byte 3 (bits 31:24) last, and data pins 15:8 stay zero.
- R3: In 16-bit mode each word yields two items, bits 15:0 first and then bits 31:16.
- R4: The strobe is driven to the level of the polarity input while active and to the opposite level at all other times, including idle.
- R5: Between two items of the same word the strobe stays inactive for hold + max(setup,1) cycles; the new item is on the pins for max(setup,1) cycles before the strobe becomes active.
- R6: The strobe stays active for exactly max(width,1) cycles per item, and the data pins are stable while it is active.
- R7: The previous item stays on the pins for the first hold cycles after the strobe becomes inactive.
- R8: Word k of a run is read from the start address + 4k. A read request is held with a stable address until valid is returned, and the strobe stays inactive while the request is open. An item that starts a new word follows the previous strobe after at least hold + max(setup,1) + 1 inactive cycles.
- R9: Read addresses wrap from the top of the window to address 0.
- R10: Exactly count strobes are produced, then one single-cycle interrupt pulse with the strobe inactive. A count of zero produces no read, no strobe and no interrupt.
- R11: Clearing start stops the engine by the next cycle: the strobe is inactive, no read is requested and no interrupt follows.
- R12: A run begins only on a rising edge of start. Holding start high after completion starts nothing further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Run enable; rising edge launches a run |
| cfg_wide | input | 1 | 1 selects 16-bit items, 0 selects 8-bit items |
| cfg_strb_hi | input | 1 | Active level of the strobe |
| cfg_setup | input | TW (8) | Setup cycles before strobe |
| cfg_active | input | TW (8) | Strobe active cycles |
| cfg_hold | input | TW (8) | Hold cycles after strobe |
| cfg_count | input | CW (16) | Items per run |
| cfg_base | input | AW (19) | Start byte address, word aligned |
| ram_req | output | 1 | Word read request |
| ram_addr | output | AW (19) | Word read byte address |
| ram_valid | input | 1 | Read data valid, completes the request |
| ram_rdata | input | 32 | Read data word |
| pin_data | output | 16 | External data bus |
| pin_strobe | output | 1 | External strobe |
| irq | output | 1 | End-of-run interrupt pulse |

## Verification
The bench mixes random timing, widths, counts and read latencies with directed runs. It measures every strobe gap and width, so an off-by-one in any phase counter, or a zero setup or width that is not raised to one, shows as a wrong gap or width. It drives runs that cross word boundaries and the top of the window, where a wrong lane order gives wrong items and a missing wrap gives an address past the window. It also drives a zero count, a mid-run stop and a start held high after completion, where a faulty design would emit stray strobes, a stray interrupt or a second run.

// File: rtl/poe_pkg.sv
package poe_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_HOLD   = 2'd3
    } poe_phase_e;
endpackage

// File: rtl/poe_lane_sel.sv
module poe_lane_sel (
    input  logic [31:0] word,
    input  logic [1:0]  lane,
    input  logic        wide,
    output logic [15:0] item
);
    always_comb begin
        if (wide) begin
            item = lane[0] ? word[31:16] : word[15:0];
        end else begin
            case (lane)
                2'd0:    item = {8'h00, word[7:0]};
                2'd1:    item = {8'h00, word[15:8]};
                2'd2:    item = {8'h00, word[23:16]};
                default: item = {8'h00, word[31:24]};
            endcase
        end
    end
endmodule

// File: rtl/poe_span.sv
module poe_span #(
    parameter int TW   = 8,
    parameter bit MIN1 = 1'b1
) (
    input  logic [TW-1:0] tmr,
    input  logic [TW-1:0] len,
    output logic          done
);
    logic [TW:0] eff;
    generate
        if (MIN1) begin : g_min1
            assign eff = (len == '0) ? (TW+1)'(1) : {1'b0, len};
        end else begin : g_raw
            assign eff = {1'b0, len};
        end
    endgenerate
    assign done = ({1'b0, tmr} + (TW+1)'(1)) >= eff;
endmodule

// File: rtl/poe_word_step.sv
module poe_word_step #(
    parameter int WW    = 17,
    parameter int WORDS = 131072
) (
    input  logic [WW-1:0] idx,
    output logic [WW-1:0] nxt
);
    generate
        if (WORDS == (1 << WW)) begin : g_pow2
            assign nxt = idx + WW'(1);
        end else begin : g_mod
            assign nxt = (idx == WW'(WORDS - 1)) ? '0 : idx + WW'(1);
        end
    endgenerate
endmodule

// File: rtl/par_out_engine.sv
module par_out_engine #(
    parameter int WIN_BYTES = 524288,
    parameter int AW        = $clog2(WIN_BYTES),
    parameter int TW        = 8,
    parameter int CW        = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_start,
    input  logic          cfg_wide,
    input  logic          cfg_strb_hi,
    input  logic [TW-1:0] cfg_setup,
    input  logic [TW-1:0] cfg_active,
    input  logic [TW-1:0] cfg_hold,
    input  logic [CW-1:0] cfg_count,
    input  logic [AW-1:0] cfg_base,
    output logic          ram_req,
    output logic [AW-1:0] ram_addr,
    input  logic          ram_valid,
    input  logic [31:0]   ram_rdata,
    output logic [15:0]   pin_data,
    output logic          pin_strobe,
    output logic          irq
);
    import poe_pkg::*;

    localparam int WW    = AW - 2;
    localparam int WORDS = WIN_BYTES / 4;

    typedef struct packed {
        poe_phase_e    phase;
        logic          start_seen;
        logic [WW-1:0] word_idx;
        logic [CW-1:0] left;
        logic [1:0]    lane;
        logic          word_ok;
        logic [31:0]   word;
        logic [15:0]   data;
        logic [TW-1:0] tmr;
        logic          irq;
    } eng_state_t;

    eng_state_t st_d, st_q;

    logic          setup_done, act_done, hold_done;
    logic [15:0]   item_fetch, item_next;
    logic [1:0]    lane_nx;
    logic [WW-1:0] idx_nx;
    logic          last_lane;

    assign lane_nx   = st_q.lane + 2'd1;
    assign last_lane = cfg_wide ? (st_q.lane == 2'd1) : (st_q.lane == 2'd3);

    poe_span #(.TW(TW), .MIN1(1'b1)) i_span_setup (
        .tmr(st_q.tmr), .len(cfg_setup), .done(setup_done));
    poe_span #(.TW(TW), .MIN1(1'b1)) i_span_active (
        .tmr(st_q.tmr), .len(cfg_active), .done(act_done));
    poe_span #(.TW(TW), .MIN1(1'b0)) i_span_hold (
        .tmr(st_q.tmr), .len(cfg_hold), .done(hold_done));

    poe_lane_sel i_sel_fetch (
        .word(ram_rdata), .lane(2'd0), .wide(cfg_wide), .item(item_fetch));
    poe_lane_sel i_sel_next (
        .word(st_q.word), .lane(lane_nx), .wide(cfg_wide), .item(item_next));

    poe_word_step #(.WW(WW), .WORDS(WORDS)) i_step (
        .idx(st_q.word_idx), .nxt(idx_nx));

    always_comb begin
        st_d            = st_q;
        st_d.irq        = 1'b0;
        st_d.start_seen = cfg_start;

        case (st_q.phase)
            PH_IDLE: begin
                if (cfg_start && !st_q.start_seen && cfg_count != '0) begin
                    st_d.phase    = PH_SETUP;
                    st_d.word_idx = cfg_base[AW-1:2];
                    st_d.left     = cfg_count;
                    st_d.lane     = 2'd0;
                    st_d.word_ok  = 1'b0;
                    st_d.tmr      = '0;
                end
            end
            PH_SETUP: begin
                if (!st_q.word_ok) begin
                    if (ram_valid) begin
                        st_d.word_ok = 1'b1;
                        st_d.word    = ram_rdata;
                        st_d.data    = item_fetch;
                        st_d.tmr     = '0;
                    end
                end else if (setup_done) begin
                    st_d.phase = PH_ACTIVE;
                    st_d.tmr   = '0;
                end else begin
                    st_d.tmr = st_q.tmr + TW'(1);
                end
            end
            default: begin
                // PH_ACTIVE and PH_HOLD share the end-of-item step
                if ((st_q.phase == PH_ACTIVE && act_done && cfg_hold == '0) ||
                    (st_q.phase == PH_HOLD && hold_done)) begin
                    st_d.left = st_q.left - CW'(1);
                    st_d.tmr  = '0;
                    if (st_q.left == CW'(1)) begin
                        st_d.phase = PH_IDLE;
                        st_d.irq   = 1'b1;
                    end else if (last_lane) begin
                        st_d.phase    = PH_SETUP;
                        st_d.word_ok  = 1'b0;
                        st_d.word_idx = idx_nx;
                        st_d.lane     = 2'd0;
                    end else begin
                        st_d.phase = PH_SETUP;
                        st_d.lane  = lane_nx;
                        st_d.data  = item_next;
                    end
                end else if (st_q.phase == PH_ACTIVE && act_done) begin
                    st_d.phase = PH_HOLD;
                    st_d.tmr   = '0;
                end else begin
                    st_d.tmr = st_q.tmr + TW'(1);
                end
            end
        endcase

        if (!cfg_start) begin
            st_d.phase = PH_IDLE;
            st_d.irq   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_req    = (st_q.phase == PH_SETUP) && !st_q.word_ok;
    assign ram_addr   = {st_q.word_idx, 2'b00};
    assign pin_data   = st_q.data;
    assign pin_strobe = (st_q.phase == PH_ACTIVE) ? cfg_strb_hi : !cfg_strb_hi;
    assign irq        = st_q.irq;
endmodule

// File: rtl/poe_checker.sv
module poe_checker #(
    parameter int AW = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_start,
    input logic          cfg_strb_hi,
    input logic          ram_req,
    input logic [AW-1:0] ram_addr,
    input logic          ram_valid,
    input logic [15:0]   pin_data,
    input logic          pin_strobe,
    input logic          irq
);
    logic act;
    assign act = (pin_strobe == cfg_strb_hi);

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && !ram_valid && cfg_start) |=> (ram_req && $stable(ram_addr)));

    assert_wait_inactive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_req |-> !act);

    assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_quiet_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !act);

    assert_stop_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_start |=> (!act && !ram_req && !irq));

    assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        act ##1 act |-> $stable(pin_data));
endmodule

bind par_out_engine poe_checker #(.AW(AW)) i_poe_checker (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_strb_hi(cfg_strb_hi),
    .ram_req(ram_req), .ram_addr(ram_addr), .ram_valid(ram_valid),
    .pin_data(pin_data), .pin_strobe(pin_strobe), .irq(irq));

// File: tb/test_par_out_engine.sv
`timescale 1ns/1ps
module test_par_out_engine;
    localparam int WIN = 524288;
    localparam int AW  = 19;
    localparam int WORDS = WIN / 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_start = 1'b0, cfg_wide = 1'b0, cfg_strb_hi = 1'b1;
    logic [7:0] cfg_setup = '0, cfg_active = '0, cfg_hold = '0;
    logic [15:0] cfg_count = '0;
    logic [AW-1:0] cfg_base = '0;
    logic ram_req, ram_valid = 1'b0;
    logic [AW-1:0] ram_addr;
    logic [31:0] ram_rdata = '0;
    logic [15:0] pin_data;
    logic pin_strobe, irq;

    always #2.5 clk = ~clk;

    par_out_engine i_par_out_engine (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_wide(cfg_wide),
        .cfg_strb_hi(cfg_strb_hi), .cfg_setup(cfg_setup), .cfg_active(cfg_active),
        .cfg_hold(cfg_hold), .cfg_count(cfg_count), .cfg_base(cfg_base),
        .ram_req(ram_req), .ram_addr(ram_addr), .ram_valid(ram_valid),
        .ram_rdata(ram_rdata), .pin_data(pin_data), .pin_strobe(pin_strobe), .irq(irq));

    int checks = 0, errors = 0;
    int lat = 0, lat_cnt = 0;
    bit mon_on = 0;
    int seen, irq_cnt, fetch_cnt, gap, width;
    bit prev_act;
    logic [15:0] cur;

    function automatic logic [31:0] mem_word(input int unsigned idx);
        logic [31:0] v;
        v = 32'(idx) * 32'h9E3779B1;
        return v ^ 32'h5A5A1234;
    endfunction

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int ipw();
        return cfg_wide ? 2 : 4;
    endfunction

    function automatic logic [15:0] exp_item(input int k);
        int w, ln;
        logic [31:0] d;
        w  = k / ipw();
        ln = k % ipw();
        d  = mem_word((int'(cfg_base) / 4 + w) % WORDS);
        if (cfg_wide) return ln[0] ? d[31:16] : d[15:0];
        return {8'h00, d[8*ln +: 8]};
    endfunction

    function automatic logic [AW-1:0] exp_addr(input int f);
        return AW'(((int'(cfg_base) / 4 + f) % WORDS) * 4);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act_v, input longint exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
        end
    endtask

    // RAM model: answers an open request after lat extra cycles
    always @(posedge clk) begin
        #1;
        if (ram_req) begin
            if (lat_cnt >= lat) begin
                ram_valid = 1'b1;
                ram_rdata = mem_word(int'(ram_addr) / 4);
                lat_cnt = 0;
            end else begin
                ram_valid = 1'b0;
                lat_cnt++;
            end
        end else begin
            ram_valid = 1'b0;
            lat_cnt = 0;
        end
    end

    // Pin monitor
    always @(negedge clk) begin
        if (mon_on) begin
            bit a;
            a = (pin_strobe == cfg_strb_hi);
            if (ram_req && ram_valid) begin
                chk(ram_addr == exp_addr(fetch_cnt), "R8/R9 read address", ram_addr, exp_addr(fetch_cnt));
                fetch_cnt++;
            end
            if (a && !prev_act) begin
                chk(pin_data == exp_item(seen), cfg_wide ? "R3 item" : "R2 item", pin_data, exp_item(seen));
                if (seen > 0) begin
                    if (seen % ipw() != 0)
                        chk(gap == int'(cfg_hold) + eff(int'(cfg_setup)), "R5 inactive gap", gap,
                            int'(cfg_hold) + eff(int'(cfg_setup)));
                    else
                        chk(gap >= int'(cfg_hold) + eff(int'(cfg_setup)) + 1, "R8 word gap", gap,
                            int'(cfg_hold) + eff(int'(cfg_setup)) + 1);
                end
                cur = pin_data;
                width = 1;
            end else if (a) begin
                width++;
                chk(pin_data == cur, "R6 data stable", pin_data, cur);
            end
            if (!a && prev_act) begin
                chk(width == eff(int'(cfg_active)), "R6 strobe width", width, eff(int'(cfg_active)));
                seen++;
                gap = 0;
            end
            if (!a) begin
                if (seen > 0 && gap < int'(cfg_hold))
                    chk(pin_data == cur, "R7 hold data", pin_data, cur);
                gap++;
            end
            if (irq) begin
                irq_cnt++;
                chk(seen == int'(cfg_count), "R10 irq after last item", seen, cfg_count);
                chk(!a, "R10 strobe inactive at irq", a, 0);
            end
            prev_act = a;
        end
    end

    task automatic setup_job(input bit wide, input bit pol, input int s, input int ac,
                             input int h, input int n, input int base, input int l);
        @(posedge clk); #1;
        cfg_wide = wide; cfg_strb_hi = pol;
        cfg_setup = 8'(s); cfg_active = 8'(ac); cfg_hold = 8'(h);
        cfg_count = 16'(n); cfg_base = AW'(base & ~3); lat = l;
        seen = 0; irq_cnt = 0; fetch_cnt = 0; gap = 0; width = 0; prev_act = 0;
        @(negedge clk);
        chk(pin_strobe == !pol, "R4 idle level", pin_strobe, !pol);
        @(posedge clk); #1;
        mon_on = 1;
        cfg_start = 1'b1;
    endtask

    task automatic run_job(input bit wide, input bit pol, input int s, input int ac,
                           input int h, input int n, input int base, input int l,
                           input bit keep);
        int t;
        setup_job(wide, pol, s, ac, h, n, base, l);
        t = 0;
        while (irq_cnt == 0 && t < 5000) begin
            @(posedge clk); t++;
        end
        chk(irq_cnt == 1, "R10 interrupt raised", irq_cnt, 1);
        if (keep) begin
            repeat (40) @(posedge clk);
            chk(seen == n && fetch_cnt == (n + (wide ? 2 : 4) - 1) / (wide ? 2 : 4),
                "R12 no relaunch while start high", seen, n);
        end
        repeat (3) @(posedge clk);
        chk(seen == n, "R10 strobe count", seen, n);
        chk(irq_cnt == 1, "R10 single interrupt", irq_cnt, 1);
        #1;
        mon_on = 0;
        cfg_start = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(pin_strobe == 1'b0, "R1 reset strobe", pin_strobe, 0);
        chk(ram_req == 1'b0 && irq == 1'b0, "R1 reset req/irq", {ram_req, irq}, 0);
        chk(pin_data == 16'h0, "R1 reset data", pin_data, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // directed corners
        run_job(1'b0, 1'b1, 0, 0, 0, 9, 64, 0, 1'b0);            // R2 min phases
        run_job(1'b1, 1'b0, 3, 2, 4, 7, 1024, 2, 1'b0);          // R3 R4 low-active
        run_job(1'b0, 1'b1, 1, 1, 2, 12, WIN - 8, 1, 1'b0);      // R9 wrap
        run_job(1'b1, 1'b1, 2, 3, 0, 5, WIN - 4, 3, 1'b1);       // R9 R12

        // R10 zero count
        setup_job(1'b0, 1'b1, 1, 1, 1, 0, 0, 0);
        repeat (20) @(posedge clk);
        chk(fetch_cnt == 0 && seen == 0, "R10 zero count no activity", seen, 0);
        chk(irq_cnt == 0, "R10 zero count no irq", irq_cnt, 0);
        #1 mon_on = 0; cfg_start = 1'b0;
        repeat (2) @(posedge clk);

        // R11 stop mid-run
        setup_job(1'b0, 1'b1, 2, 2, 2, 40, 256, 1);
        t = 0;
        while (seen < 3 && t < 2000) begin @(posedge clk); t++; end
        #1 mon_on = 0; cfg_start = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(pin_strobe == 1'b0 && ram_req == 1'b0, "R11 stop idle", {pin_strobe, ram_req}, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(pin_strobe == 1'b0 && irq == 1'b0 && ram_req == 1'b0, "R11 stays stopped",
                {pin_strobe, irq, ram_req}, 0);
        end

        // random runs
        for (int j = 0; j < 14; j++) begin
            run_job(1'($urandom), 1'($urandom), int'($urandom % 5), int'($urandom % 5),
                    int'($urandom % 5), 1 + int'($urandom % 12), int'($urandom % WIN),
                    int'($urandom % 4), 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule